// File: doc/BRIEF.md
# Byte-Stuffed HDLC Frame Transmitter

This block turns a stream of packet bytes into a byte-oriented HDLC stream for a transmit ring buffer. Upstream offers bytes on a valid/ready interface, with markers for the first and last byte of each packet. Downstream takes one byte per accepted cycle. The block puts a flag byte before and after every packet. Between back-to-back packets it sends only one flag. The two reserved values are replaced by a two-byte escape. While no packet is in progress, it sends flag bytes without a break.

The flag (7Eh) and the escape lead byte (7Dh) never appear raw inside a frame. The escape lead is followed by the reserved value XOR 20h. While the second escape byte or a flag is being sent, the input is held off. A stall by the downstream side freezes the output byte.

Top module: `hdlc_bytestuff_tx`

## Requirements
- R1: The flag value is 7Eh. Seen from idle, the flag accepted while a start-of-packet byte is offered is the opening flag, and the first payload byte comes out on the next accepted cycle.
- R2: A payload byte 7Eh is emitted as 7Dh, then 5Eh.
- R3: A payload byte 7Dh is emitted as 7Dh, then 5Dh.
- R4: After the last byte of a packet (after both escape bytes if it was escaped), one flag 7Eh is emitted. If a start-of-packet byte is offered when that flag is accepted, that flag also opens the next packet, and the next payload byte follows it directly.
- R5: Every other payload byte value passes through unchanged, in order.
- R6: After reset and whenever no packet is in progress, out_valid is 1 and out_data is 7Eh on every cycle.
- R7: in_ready is 0 while the second byte of an escape pair is offered, and while a flag is offered for a start-of-packet byte.
- R8: While out_ready is 0, in_ready is 0, and an offered output byte stays on out_data until it is accepted.
- R9: If input runs dry inside a packet, out_valid drops to 0 and no flag is inserted. The packet resumes when input returns.
- R10: An input byte offered outside a packet without the start-of-packet marker is consumed (in_ready 1 when out_ready is 1) and discarded. The output keeps sending flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_sop | input | 1 | Offered byte is the first of a packet |
| in_eop | input | 1 | Offered byte is the last of a packet |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Input byte is taken this cycle |
| out_valid | output | 1 | Output byte offered |
| out_data | output | 8 | Framed stream byte |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
The bench sends a packet sequence that covers each case at least once: an escaped byte in the middle of a packet, a packet of one escaped byte, an escaped final byte, and packets sent back to back. A design that repeated the flag between packets, or left out the closing flag, would shift every later byte against the expected stream. Directed cases hold out_ready low while an escape lead is offered; a design that consumed input there would lose bytes. They also starve the input in mid-packet; a design that filled the gap with a flag would split the frame. Finally, they offer a stray byte with no start marker during idle; a design that did not discard it would either stall or leak data between flags.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] DEF_FLAG = 8'h7E;
    localparam logic [BYTE_W-1:0] DEF_ESC  = 8'h7D;
    localparam logic [BYTE_W-1:0] DEF_XMSK = 8'h20;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_ESC2,
        ST_CLOSE
    } tx_state_e;

    typedef struct packed {
        tx_state_e         st;
        logic [BYTE_W-1:0] tail;
        logic              tail_eop;
    } tx_regs_t;

endpackage

// File: rtl/hdlc_esc_map.sv
module hdlc_esc_map
    import hdlc_tx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FLAG_BYTE = DEF_FLAG,
    parameter logic [BYTE_W-1:0] ESC_BYTE  = DEF_ESC,
    parameter logic [BYTE_W-1:0] XOR_MASK  = DEF_XMSK
) (
    input  logic [BYTE_W-1:0] byte_i,
    output logic              reserved_o,
    output logic [BYTE_W-1:0] tail_o
);

    always_comb begin
        reserved_o = (byte_i == FLAG_BYTE) || (byte_i == ESC_BYTE);
        tail_o     = byte_i ^ XOR_MASK;
    end

endmodule

// File: rtl/hdlc_tx_fsm.sv
module hdlc_tx_fsm
    import hdlc_tx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FLAG_BYTE = DEF_FLAG,
    parameter logic [BYTE_W-1:0] ESC_BYTE  = DEF_ESC,
    parameter logic [BYTE_W-1:0] XOR_MASK  = DEF_XMSK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic              in_sop_i,
    input  logic              in_eop_i,
    input  logic [BYTE_W-1:0] in_data_i,
    input  logic              reserved_i,
    input  logic [BYTE_W-1:0] tail_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    output logic [BYTE_W-1:0] out_data_o,
    input  logic              out_ready_i
);

    tx_regs_t r_d, r_q;

    always_comb begin
        r_d         = r_q;
        out_valid_o = 1'b0;
        out_data_o  = FLAG_BYTE;
        in_ready_o  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                out_valid_o = 1'b1;
                out_data_o  = FLAG_BYTE;
                // stray byte outside a packet is drained
                if (in_valid_i && !in_sop_i) begin
                    in_ready_o = out_ready_i;
                end
                if (out_ready_i && in_valid_i && in_sop_i) begin
                    r_d.st = ST_DATA;
                end
            end
            ST_DATA: begin
                out_valid_o = in_valid_i;
                out_data_o  = reserved_i ? ESC_BYTE : in_data_i;
                in_ready_o  = out_ready_i;
                if (in_valid_i && out_ready_i) begin
                    if (reserved_i) begin
                        r_d.st       = ST_ESC2;
                        r_d.tail     = tail_i;
                        r_d.tail_eop = in_eop_i;
                    end else if (in_eop_i) begin
                        r_d.st = ST_CLOSE;
                    end
                end
            end
            ST_ESC2: begin
                out_valid_o = 1'b1;
                out_data_o  = r_q.tail;
                if (out_ready_i) begin
                    r_d.st = r_q.tail_eop ? ST_CLOSE : ST_DATA;
                end
            end
            ST_CLOSE: begin
                out_valid_o = 1'b1;
                out_data_o  = FLAG_BYTE;
                if (out_ready_i) begin
                    r_d.st = (in_valid_i && in_sop_i) ? ST_DATA : ST_IDLE;
                end
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st       <= ST_IDLE;
            r_q.tail     <= '0;
            r_q.tail_eop <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    AST_ESC_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_ready_i && out_data_o == ESC_BYTE |=>
        out_valid_o && (out_data_o == (FLAG_BYTE ^ XOR_MASK) || out_data_o == (ESC_BYTE ^ XOR_MASK))); // R2
    AST_ESC_INPUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_ready_i && out_data_o == ESC_BYTE |=> !in_ready_o); // R7
    AST_EOP_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i && in_ready_o && in_eop_i && !reserved_i |=> out_valid_o && out_data_o == FLAG_BYTE); // R4
    AST_READY_NEEDS_SINK: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> out_ready_i); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i && (r_q.st != ST_DATA) |=> out_valid_o && $stable(out_data_o)); // R8

endmodule

// File: rtl/hdlc_bytestuff_tx.sv
module hdlc_bytestuff_tx
    import hdlc_tx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] FLAG_BYTE = DEF_FLAG,
    parameter logic [BYTE_W-1:0] ESC_BYTE  = DEF_ESC,
    parameter logic [BYTE_W-1:0] XOR_MASK  = DEF_XMSK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    input  logic              out_ready
);

    logic              reserved_w;
    logic [BYTE_W-1:0] tail_w;

    hdlc_esc_map #(
        .FLAG_BYTE (FLAG_BYTE),
        .ESC_BYTE  (ESC_BYTE),
        .XOR_MASK  (XOR_MASK)
    ) esc_map_i (
        .byte_i     (in_data),
        .reserved_o (reserved_w),
        .tail_o     (tail_w)
    );

    hdlc_tx_fsm #(
        .FLAG_BYTE (FLAG_BYTE),
        .ESC_BYTE  (ESC_BYTE),
        .XOR_MASK  (XOR_MASK)
    ) fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid_i  (in_valid),
        .in_sop_i    (in_sop),
        .in_eop_i    (in_eop),
        .in_data_i   (in_data),
        .reserved_i  (reserved_w),
        .tail_i      (tail_w),
        .in_ready_o  (in_ready),
        .out_valid_o (out_valid),
        .out_data_o  (out_data),
        .out_ready_i (out_ready)
    );

endmodule

// File: tb/hdlc_bytestuff_tx_tb.sv
`timescale 1ns/100ps
module hdlc_bytestuff_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hdlc_bytestuff_tx dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready)
    );

    // {sop, eop, data}
    localparam int NV = 11;
    localparam logic [9:0] VEC [NV] = '{
        {2'b10, 8'h11}, {2'b00, 8'h7E}, {2'b00, 8'h22}, {2'b00, 8'h7D},
        {2'b01, 8'h5E}, {2'b11, 8'h7E}, {2'b10, 8'h00}, {2'b00, 8'hFF},
        {2'b01, 8'h7D}, {2'b10, 8'h7F}, {2'b01, 8'h20}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic e,
                         input logic [7:0] d, input logic rdy);
        @(negedge clk);
        in_valid = v; in_sop = s; in_eop = e; in_data = d; out_ready = rdy;
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] exp_b [32];
        string      exp_t [32];
        int         ne;
        int         idx;
        int         got;
        int         guard;

        // reset state
        repeat (3) drive(0, 0, 0, 8'h00, 1);
        chk("R6 reset out_valid", out_valid, 1);
        chk("R6 reset out_data", out_data, 8'h7E);
        chk("R7 reset in_ready", in_ready, 0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            drive(0, 0, 0, 8'h00, 1);
            chk("R6 idle flag", out_data, 8'h7E);
            chk("R6 idle valid", out_valid, 1);
        end

        // expected stream from the requirements
        ne = 0;
        exp_b[ne] = 8'h7E; exp_t[ne] = "R1 opening flag"; ne++;
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][7:0] == 8'h7E || VEC[i][7:0] == 8'h7D) begin
                exp_b[ne] = 8'h7D; exp_t[ne] = "R2 escape lead"; ne++;
                exp_b[ne] = VEC[i][7:0] ^ 8'h20;
                exp_t[ne] = (VEC[i][7:0] == 8'h7E) ? "R2 escape tail" : "R3 escape tail";
                ne++;
            end else begin
                exp_b[ne] = VEC[i][7:0]; exp_t[ne] = "R5 plain byte"; ne++;
            end
            if (VEC[i][8]) begin
                exp_b[ne] = 8'h7E; exp_t[ne] = "R4 closing/shared flag"; ne++;
            end
        end

        // table walk, sink always ready
        idx = 0; got = 0; guard = 0;
        while (got < ne && guard < 200) begin
            if (idx < NV) drive(1, VEC[idx][9], VEC[idx][8], VEC[idx][7:0], 1);
            else          drive(0, 0, 0, 8'h00, 1);
            if (out_valid && out_ready) begin
                chk(exp_t[got], out_data, exp_b[got]);
                got++;
            end
            if (in_valid && in_ready) idx++;
            guard++;
        end
        chk("R4 stream length", got, ne);
        drive(0, 0, 0, 8'h00, 1);
        chk("R6 idle after packet", out_data, 8'h7E);

        // stray byte in idle
        drive(1, 0, 0, 8'h42, 1);
        chk("R10 stray consumed", in_ready, 1);
        chk("R10 stray not emitted", out_data, 8'h7E);
        drive(0, 0, 0, 8'h00, 1);
        chk("R10 flags continue", out_data, 8'h7E);
        chk("R10 valid continue", out_valid, 1);

        // backpressure on an escape
        drive(1, 1, 0, 8'h7E, 1);
        chk("R7 held during opening flag", in_ready, 0);
        drive(1, 1, 0, 8'h7E, 0);
        chk("R2 lead under stall", out_data, 8'h7D);
        chk("R8 no input under stall", in_ready, 0);
        drive(1, 1, 0, 8'h7E, 0);
        chk("R8 byte held", out_data, 8'h7D);
        chk("R8 valid held", out_valid, 1);
        drive(1, 1, 0, 8'h7E, 1);
        chk("R2 lead accepted", in_ready, 1);
        drive(1, 0, 1, 8'h7D, 1);
        chk("R2 tail 5E", out_data, 8'h5E);
        chk("R7 held during tail", in_ready, 0);
        drive(1, 0, 1, 8'h7D, 1);
        chk("R3 lead", out_data, 8'h7D);
        chk("R3 lead consumed", in_ready, 1);
        drive(0, 0, 0, 8'h00, 1);
        chk("R3 tail 5D", out_data, 8'h5D);
        drive(0, 0, 0, 8'h00, 1);
        chk("R4 close after escaped last", out_data, 8'h7E);
        chk("R4 close valid", out_valid, 1);
        drive(0, 0, 0, 8'h00, 1);
        chk("R6 back to idle", out_data, 8'h7E);

        // underrun in mid-packet
        drive(1, 1, 0, 8'h31, 1);
        drive(1, 1, 0, 8'h31, 1);
        chk("R5 first byte", out_data, 8'h31);
        drive(0, 0, 0, 8'h00, 1);
        chk("R9 gap no output", out_valid, 0);
        drive(0, 0, 0, 8'h00, 1);
        chk("R9 gap still quiet", out_valid, 0);
        drive(1, 0, 1, 8'h32, 1);
        chk("R9 resume byte", out_data, 8'h32);
        chk("R9 resume valid", out_valid, 1);
        drive(0, 0, 0, 8'h00, 1);
        chk("R4 close after resume", out_data, 8'h7E);

        finish_run();
    end

endmodule